// File: doc/BRIEF.md
# Half-Band Two-Times Interpolator

This block doubles the sample rate of a single channel of signed PCM audio. Conceptually it places a zero-valued sample between every two input samples. It then removes the spectral images that the zero-stuffing creates with a linear-phase half-band low-pass FIR. The -6 dB point of that filter lies exactly at half the input sample rate.

The filter never forms the zero-stuffed stream. Each accepted input sample yields two output beats. The first is the centre phase: a delayed copy of an earlier input that passes through unscaled. The second is the interpolated phase: the weighted sum of the odd-indexed taps. The even taps of a half-band filter are zero, so they cost nothing. The odd taps are symmetric, so mirrored sample pairs are added before the multiply. That leaves one multiplier per non-zero coefficient on one side of the centre. The coefficients are a raised-cosine-windowed sinc segment, computed at elaboration from the parameters. They are already scaled by two to restore unity passband gain after zero-stuffing.

The upstream source presents samples with a valid/ready handshake. The block accepts at most one sample every second cycle and emits the two resulting beats on consecutive cycles. The output stream therefore runs at twice the input rate when the input is saturated.

Top module: `hb_interp2x`

## Requirements
- R1: For a sample accepted at clock edge E, out_valid_o is high on the cycles after edges E+3 and E+4, carrying the centre beat first and the interpolated beat second. No beat appears without a preceding accept.
- R2: in_ready_o is high out of reset and after any cycle without an accept. It is low for exactly the one cycle after each accept.
- R3: The centre beat equals, bit for bit, the sample accepted HALF_TAPS accepts before the current one, with zeros before any such sample exists.
- R4: The interpolated beat is the sum over j = 0..HALF_TAPS-1 of c_j * (x[n-HALF_TAPS+1+j] + x[n-HALF_TAPS-j]), where x[n] is the newest accept. That sum is rounded by adding 2^(COEF_W-2) and shifting arithmetically right by COEF_W-1. The coefficient c_j, with k = 2j+1, is (-1)^j * 2/(pi*k) * 0.5*(1+cos(pi*k/(2*HALF_TAPS))), quantised to signed COEF_W bits with COEF_W-1 fraction bits, rounding half away from zero.
- R5: An impulse input produces interpolated beats that reproduce the coefficient set mirrored about the centre, with the lone non-zero centre beat equal to the impulse amplitude.
- R6: Interpolated results beyond the signed DATA_W range clamp to 2^(DATA_W-1)-1 or -2^(DATA_W-1).
- R7: While rst_ni is low: out_valid_o is 0, out_data_o is 0, in_ready_o is 1, and every stored sample is cleared to zero.
- R8: out_data_o is zero on every cycle on which out_valid_o is low.
- R9: Cycles without an accept leave the stored history untouched, so values after an input stall continue the same sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Input sample present |
| in_ready_o | output | 1 | Block can take a sample this cycle |
| in_data_i | input | DATA_W | Signed input sample |
| out_valid_o | output | 1 | Output beat present |
| out_data_o | output | DATA_W | Signed output sample at twice the input rate |

## Verification
The assertions watch the handshake rhythm on every cycle. They check the one-cycle ready gap after each accept, the two-beat output burst exactly four sampled edges after an accept, that no beat appears without a cause, and the quiet zero data bus between bursts. The arithmetic is left to the bench: the delayed centre copy, the rounded pre-added dot product, the mirrored impulse response, clamping at both rails and history preservation across stalls. Only a reference model fed with concrete sample sequences can show that these values are right.

// File: rtl/hb_interp_pkg.sv
package hb_interp_pkg;

  localparam real PI = 3.14159265358979323846;

  // Elaboration-time cosine; argument stays below pi for every tap used.
  function automatic real cos_series(real x);
    real term;
    real acc;
    term = 1.0;
    acc  = 1.0;
    for (int i = 1; i < 24; i++) begin
      term = -term * x * x / real'((2 * i - 1) * (2 * i));
      acc  = acc + term;
    end
    return acc;
  endfunction

  // Odd-tap coefficient j (tap index 2j+1), doubled for zero-stuffing gain.
  function automatic longint odd_coef(int j, int half_taps, int frac);
    real k;
    real win;
    real mag;
    real scaled;
    k      = real'(2 * j + 1);
    win    = 0.5 * (1.0 + cos_series(PI * k / real'(2 * half_taps)));
    mag    = 2.0 / (PI * k) * win;
    scaled = ((j % 2) == 0 ? mag : -mag) * (2.0 ** frac);
    if (scaled >= 0.0) return longint'($rtoi(scaled + 0.5));
    else               return -longint'($rtoi(-scaled + 0.5));
  endfunction

endpackage

// File: rtl/hb_delay_line.sv
module hb_delay_line #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         shift_i,
  input  logic [DATA_W-1:0]            din_i,
  output logic [DEPTH-1:0][DATA_W-1:0] taps_o
);

  logic [DEPTH-1:0][DATA_W-1:0] stage_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    logic [DATA_W-1:0] nxt;
    if (i == 0) begin : g_head
      assign nxt = din_i;
    end else begin : g_body
      assign nxt = stage_q[i-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      stage_q[i] <= '0;
      else if (shift_i) stage_q[i] <= nxt;
    end
  end

  assign taps_o = stage_q;

endmodule

// File: rtl/hb_pair_mac.sv
module hb_pair_mac
  import hb_interp_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int COEF_W    = 18,
  parameter int HALF_TAPS = 8,
  localparam int DEPTH    = 2 * HALF_TAPS,
  localparam int FRAC     = COEF_W - 1,
  localparam int PAIR_W   = DATA_W + 1,
  localparam int PROD_W   = PAIR_W + COEF_W
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             pre_en_i,
  input  logic                             mul_en_i,
  input  logic [DEPTH-1:0][DATA_W-1:0]     taps_i,
  output logic [HALF_TAPS-1:0][PROD_W-1:0] prod_o
);

  for (genvar j = 0; j < HALF_TAPS; j++) begin : g_tap
    localparam longint CoefL = odd_coef(j, HALF_TAPS, FRAC);
    localparam logic [63:0] CoefBits = CoefL;
    logic signed [COEF_W-1:0] coef;
    logic signed [PAIR_W-1:0] pair_q;
    logic signed [PROD_W-1:0] prod_q;

    assign coef = CoefBits[COEF_W-1:0];

    // mirrored pair around the interpolation point
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pair_q <= '0;
      else if (pre_en_i)
        pair_q <= PAIR_W'($signed(taps_i[HALF_TAPS-1-j])) + PAIR_W'($signed(taps_i[HALF_TAPS+j]));
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prod_q <= '0;
      else if (mul_en_i) prod_q <= PROD_W'(pair_q) * PROD_W'(coef);
    end

    assign prod_o[j] = prod_q;
  end

endmodule

// File: rtl/hb_sum_round.sv
module hb_sum_round #(
  parameter int PROD_W    = 35,
  parameter int HALF_TAPS = 8,
  parameter int DATA_W    = 16,
  parameter int FRAC      = 17,
  localparam int LVLS     = $clog2(HALF_TAPS),
  localparam int LEAVES   = 1 << LVLS,
  localparam int ACC_W    = PROD_W + LVLS + 1
) (
  input  logic [HALF_TAPS-1:0][PROD_W-1:0] prod_i,
  output logic [DATA_W-1:0]                y_o
);

  localparam logic signed [ACC_W-1:0] Bias = ACC_W'(64'sd1 <<< (FRAC - 1));
  localparam logic signed [ACC_W-1:0] MaxV = ACC_W'((64'sd1 <<< (DATA_W - 1)) - 64'sd1);
  localparam logic signed [ACC_W-1:0] MinV = ACC_W'(-(64'sd1 <<< (DATA_W - 1)));

  logic signed [ACC_W-1:0] node [2*LEAVES-1];

  for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
    if (i < HALF_TAPS) begin : g_used
      assign node[LEAVES-1+i] = ACC_W'($signed(prod_i[i]));
    end else begin : g_pad
      assign node[LEAVES-1+i] = '0;
    end
  end

  for (genvar i = 0; i < LEAVES - 1; i++) begin : g_tree
    assign node[i] = node[2*i+1] + node[2*i+2];
  end

  logic signed [ACC_W-1:0] biased;
  logic signed [ACC_W-1:0] shifted;

  always_comb begin
    biased  = node[0] + Bias;
    shifted = biased >>> FRAC;
    if (shifted > MaxV)      y_o = MaxV[DATA_W-1:0];
    else if (shifted < MinV) y_o = MinV[DATA_W-1:0];
    else                     y_o = shifted[DATA_W-1:0];
  end

endmodule

// File: rtl/hb_interp2x.sv
module hb_interp2x #(
  parameter int DATA_W    = 16,
  parameter int COEF_W    = 18,
  parameter int HALF_TAPS = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_data_o
);

  localparam int DEPTH  = 2 * HALF_TAPS;
  localparam int FRAC   = COEF_W - 1;
  localparam int PROD_W = DATA_W + 1 + COEF_W;

  logic                             accept;
  logic                             acc_q;
  logic [DEPTH-1:0][DATA_W-1:0]     taps;
  logic [HALF_TAPS-1:0][PROD_W-1:0] prods;
  logic [DATA_W-1:0]                interp;
  logic                             v_a_q, v_b_q, odd_pend_q, out_v_q;
  logic [DATA_W-1:0]                ctr_a_q, ctr_b_q, odd_q, out_q;

  assign in_ready_o = ~acc_q;
  assign accept     = in_valid_i & in_ready_o;

  hb_delay_line #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_line (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .shift_i(accept),
    .din_i  (in_data_i),
    .taps_o (taps)
  );

  hb_pair_mac #(.DATA_W(DATA_W), .COEF_W(COEF_W), .HALF_TAPS(HALF_TAPS)) u_mac (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pre_en_i(acc_q),
    .mul_en_i(v_a_q),
    .taps_i  (taps),
    .prod_o  (prods)
  );

  hb_sum_round #(.PROD_W(PROD_W), .HALF_TAPS(HALF_TAPS), .DATA_W(DATA_W), .FRAC(FRAC)) u_sum (
    .prod_i(prods),
    .y_o   (interp)
  );

  // centre phase rides alongside the MAC pipeline
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= 1'b0;
      v_a_q   <= 1'b0;
      v_b_q   <= 1'b0;
      ctr_a_q <= '0;
      ctr_b_q <= '0;
    end else begin
      acc_q <= accept;
      v_a_q <= acc_q;
      v_b_q <= v_a_q;
      if (acc_q) ctr_a_q <= taps[HALF_TAPS];
      if (v_a_q) ctr_b_q <= ctr_a_q;
    end
  end

  // output sequencer: centre beat, then the interpolated beat
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_v_q    <= 1'b0;
      out_q      <= '0;
      odd_q      <= '0;
      odd_pend_q <= 1'b0;
    end else if (v_b_q) begin
      out_v_q    <= 1'b1;
      out_q      <= ctr_b_q;
      odd_q      <= interp;
      odd_pend_q <= 1'b1;
    end else if (odd_pend_q) begin
      out_v_q    <= 1'b1;
      out_q      <= odd_q;
      odd_pend_q <= 1'b0;
    end else begin
      out_v_q <= 1'b0;
      out_q   <= '0;
    end
  end

  assign out_valid_o = out_v_q;
  assign out_data_o  = out_q;

endmodule

// File: rtl/hb_interp2x_chk.sv
module hb_interp2x_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_valid_i,
  input logic              in_ready_o,
  input logic              out_valid_o,
  input logic [DATA_W-1:0] out_data_o
);

  p_ready_gap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |=> !in_ready_o);

  p_ready_back_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_ready_o |=> in_ready_o);

  p_beat_pair_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |-> ##4 out_valid_o ##1 out_valid_o);

  p_no_spurious_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !$past(out_valid_o)) |-> $past(in_valid_i && in_ready_o, 4));

  p_idle_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> (out_data_o == '0));

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_reset_idle_r7: assert (!out_valid_o && in_ready_o && out_data_o == '0);
    end
  end

endmodule

bind hb_interp2x hb_interp2x_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .in_valid_i (in_valid_i),
  .in_ready_o (in_ready_o),
  .out_valid_o(out_valid_o),
  .out_data_o (out_data_o)
);

// File: tb/hb_interp2x_tb_top.sv
module hb_interp2x_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W     = 16;
  localparam int COEF_W     = 18;
  localparam int HALF       = 8;
  localparam int FRAC       = COEF_W - 1;
  localparam int MAX_CYC    = 20000;
  localparam longint VMAX   = (64'sd1 <<< (DATA_W - 1)) - 1;
  localparam longint VMIN   = -(64'sd1 <<< (DATA_W - 1));

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [DATA_W-1:0] in_data = '0;
  logic in_ready, out_valid;
  logic [DATA_W-1:0] out_data;

  always #(CLK_PERIOD / 2) clk = ~clk;

  hb_interp2x #(.DATA_W(DATA_W), .COEF_W(COEF_W), .HALF_TAPS(HALF)) dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .in_valid_i (in_valid),
    .in_ready_o (in_ready),
    .in_data_i  (in_data),
    .out_valid_o(out_valid),
    .out_data_o (out_data)
  );

  int checks = 0;
  int errors = 0;
  longint cyc = 0;
  longint wd = 0;
  bit done = 1'b0;
  bit prev_acc = 1'b0;
  bit log_odd = 1'b0;
  string ctag = "R3";
  string otag = "R4";

  longint coef[HALF];
  longint hist[$];
  longint exp_val[$];
  longint exp_cyc[$];
  string  exp_tag[$];
  bit     exp_odd[$];
  longint odd_log[$];

  task automatic check(bit ok, string tag, longint act, longint expv, string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  function automatic longint clamp(longint v);
    if (v > VMAX) return VMAX;
    if (v < VMIN) return VMIN;
    return v;
  endfunction

  task automatic model_accept(longint n, longint v);
    longint s;
    hist.push_front(v);
    void'(hist.pop_back());
    s = 0;
    for (int j = 0; j < HALF; j++) s += coef[j] * (hist[HALF-1-j] + hist[HALF+j]);
    exp_cyc.push_back(n + 4); exp_val.push_back(hist[HALF]); exp_tag.push_back(ctag); exp_odd.push_back(1'b0);
    exp_cyc.push_back(n + 5); exp_val.push_back(clamp((s + (64'sd1 <<< (FRAC - 1))) >>> FRAC));
    exp_tag.push_back(otag); exp_odd.push_back(1'b1);
  endtask

  task automatic pop_exp();
    void'(exp_cyc.pop_front()); void'(exp_val.pop_front());
    void'(exp_tag.pop_front()); void'(exp_odd.pop_front());
  endtask

  // per-cycle comparison against the reference model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      cyc++;
      if (out_valid) begin
        if (exp_cyc.size() == 0 || exp_cyc[0] != cyc) begin
          check(1'b0, "R1", cyc, (exp_cyc.size() != 0) ? exp_cyc[0] : -1, "beat at unexpected cycle");
          if (exp_cyc.size() != 0 && exp_cyc[0] < cyc) pop_exp();
        end else begin
          check(longint'($signed(out_data)) == exp_val[0], exp_tag[0],
                longint'($signed(out_data)), exp_val[0], "output beat");
          if (log_odd && exp_odd[0]) odd_log.push_back(longint'($signed(out_data)));
          pop_exp();
        end
      end else begin
        if (exp_cyc.size() != 0 && exp_cyc[0] == cyc) begin
          check(1'b0, "R1", 0, 1, "missing beat");
          pop_exp();
        end
        check(out_data == '0, "R8", longint'(out_data), 0, "idle data");
      end
      if (prev_acc) check(!in_ready, "R2", longint'(in_ready), 0, "ready after accept");
      prev_acc = in_valid && in_ready;
      if (in_valid && in_ready) model_accept(cyc, longint'($signed(in_data)));
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd > MAX_CYC && !done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d cycles", wd, MAX_CYC);
      finish_run();
    end
  end

  task automatic send(longint v);
    in_valid = 1'b1;
    in_data  = v[DATA_W-1:0];
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic idle(int n);
    in_valid = 1'b0;
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic sat_pattern(bit positive);
    // oldest first: position p sits at history index p when the last sample lands
    for (int p = 2 * HALF - 1; p >= 0; p--) begin
      int j;
      bit pos;
      j   = (p >= HALF) ? p - HALF : HALF - 1 - p;
      pos = (coef[j] > 0) ^ !positive;
      send(pos ? VMAX : VMIN);
    end
  endtask

  initial begin
    for (int j = 0; j < HALF; j++) begin
      real k, sc;
      k  = real'(2 * j + 1);
      sc = ((j % 2) ? -1.0 : 1.0) * 2.0 / (3.14159265358979323846 * k)
           * 0.5 * (1.0 + $cos(3.14159265358979323846 * k / real'(2 * HALF))) * (2.0 ** FRAC);
      coef[j] = (sc >= 0.0) ? longint'($rtoi(sc + 0.5)) : -longint'($rtoi(-sc + 0.5));
    end
    for (int i = 0; i < 2 * HALF; i++) hist.push_back(0);

    // R7: reset state
    #(3 * CLK_PERIOD);
    check(!out_valid, "R7", longint'(out_valid), 0, "valid in reset");
    check(out_data == '0, "R7", longint'(out_data), 0, "data in reset");
    check(in_ready, "R7", longint'(in_ready), 1, "ready in reset");
    @(posedge clk); #1;
    rst_n = 1'b1;
    idle(3);

    // R7: cleared history gives zero output for zero input
    ctag = "R7"; otag = "R7";
    send(0);
    idle(6);

    // R5: impulse reproduces mirrored coefficients with interleaved zeros
    ctag = "R3"; otag = "R5";
    log_odd = 1'b1;
    send(VMAX);
    for (int i = 0; i < 2 * HALF + 1; i++) send(0);
    idle(8);
    log_odd = 1'b0;
    check(odd_log.size() == 2 * HALF + 2, "R5", odd_log.size(), 2 * HALF + 2, "impulse beat count");
    if (odd_log.size() == 2 * HALF + 2) begin
      for (int i = 0; i < HALF; i++)
        check(odd_log[i] == odd_log[2 * HALF - 1 - i], "R5", odd_log[i], odd_log[2 * HALF - 1 - i], "mirror");
      check(odd_log[HALF - 1] == ((coef[0] * VMAX + (64'sd1 <<< (FRAC - 1))) >>> FRAC), "R5",
            odd_log[HALF - 1], (coef[0] * VMAX + (64'sd1 <<< (FRAC - 1))) >>> FRAC, "peak tap");
      check(odd_log[2 * HALF] == 0, "R5", odd_log[2 * HALF], 0, "tail zero");
    end

    // R4: random samples with irregular gaps
    ctag = "R3"; otag = "R4";
    for (int i = 0; i < 200; i++) begin
      send(longint'($signed(16'($urandom))));
      idle($urandom_range(0, 2));
    end

    // R9: stall mid-stream, history must survive
    ctag = "R9"; otag = "R9";
    for (int i = 0; i < 6; i++) send(1000 * (i + 1) - 3500);
    idle(15);
    for (int i = 0; i < 6; i++) send(-777 * i);

    // R6: clamping at both rails
    otag = "R6"; ctag = "R3";
    odd_log.delete();
    log_odd = 1'b1;
    sat_pattern(1'b1);
    idle(8);
    check(odd_log.size() > 0 && odd_log[odd_log.size() - 1] == VMAX, "R6",
          (odd_log.size() > 0) ? odd_log[odd_log.size() - 1] : 0, VMAX, "positive rail");
    odd_log.delete();
    sat_pattern(1'b0);
    idle(8);
    log_odd = 1'b0;
    check(odd_log.size() > 0 && odd_log[odd_log.size() - 1] == VMIN, "R6",
          (odd_log.size() > 0) ? odd_log[odd_log.size() - 1] : 0, VMIN, "negative rail");

    // R1: every predicted beat arrived
    idle(10);
    check(exp_cyc.size() == 0, "R1", exp_cyc.size(), 0, "pending beats");
    finish_run();
  end

endmodule